// File: doc/BRIEF.md
# Serial DAC Host Driver

This block lets on-chip logic program an eight-channel serial DAC. A command carries a 3-bit channel number, a range bit, an 8-bit code and a 2-bit operation. It is taken in through a valid/ready handshake. For a write, the block shifts a 12-bit word out on a serial clock and data pin. It then pulses the latch strobe low so that the converter takes the word. A separate update strobe decides whether the new value reaches the output at once, or waits until a later commit operation moves every pending channel together.

All pin timing comes from down-counters in the system clock domain. Parameters give every interval as a number of system clock cycles: the serial clock half-period, the gap from the last clock edge to the latch strobe, the latch pulse width, the recovery gap after the latch, and the update pulse width. At elaboration the top module checks these counts against a 1 MHz serial clock limit, a 50 ns data setup and valid window, and 250 ns strobe widths. The check uses the system clock frequency parameter.

Top module: `dac8_serial_host`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cmd_ready`=1, `dac_sclk`=1, `dac_sdi`=0, `dac_latch_n`=1 and `dac_commit_n`=0.
- R2: A write sends exactly 12 bits, most significant first: `cmd_chan[2:0]`, then `cmd_range`, then `cmd_code[7:0]`. Each bit is the value of `dac_sdi` at a falling edge of `dac_sclk`, and `dac_sdi` does not change on that edge.
- R3: The serial clock idles high. Within a frame, each high phase and each low phase lasts HALF_CYC cycles. `dac_sdi` changes only on the edge that accepts a command or on a rising edge of `dac_sclk`, so setup and valid time are both HALF_CYC cycles.
- R4: `dac_latch_n` falls HALF_CYC+LEAD_CYC cycles after the twelfth falling clock edge, stays low for LATCH_CYC cycles, and is low only while `dac_sclk` is high.
- R5: `cmd_ready` drops in the cycle after acceptance. It returns GAP_CYC cycles after `dac_latch_n` rises, or when the update pulse ends. `cmd_valid` while `cmd_ready` is low has no effect on any output.
- R6: Operation code 00 (write, immediate) leaves `dac_commit_n` at its current level. Code 01 (write, deferred) drives `dac_commit_n` high from the accepting edge, and it stays high after the write. `dac_commit_n` never falls while `dac_latch_n` is low.
- R7: An immediate write issued while `dac_commit_n` is high keeps it high, so pending deferred channels are not committed piecemeal.
- R8: Operation codes 10 and 11 (commit) drive no serial frame. `dac_commit_n` goes high from the accepting edge (or stays high). It then falls after PULSE_CYC cycles, stays low for PULSE_CYC cycles, and `cmd_ready` returns at the end of that low phase with `dac_commit_n` left low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Driver idle, command taken when valid is also high |
| cmd_chan | input | CHAN_W | Target channel number |
| cmd_range | input | 1 | Output range select bit sent in the frame |
| cmd_code | input | CODE_W | Conversion code |
| cmd_op | input | 2 | 00 write immediate, 01 write deferred, 1x commit |
| dac_sclk | output | 1 | Serial clock to the converter |
| dac_sdi | output | 1 | Serial data to the converter |
| dac_latch_n | output | 1 | Active-low word latch strobe |
| dac_commit_n | output | 1 | Update strobe, high holds outputs, falling edge commits |

## Verification
The hardest case to reach from the ports is an immediate write that arrives while deferred writes are still pending. The update strobe must then stay high through the whole frame and latch pulse, and not let pending channels through early. The stimulus issues two deferred writes and then an immediate write, and only after that a commit operation. A second commit is issued with nothing pending, so the pulse has to come from a low level. While the driver is busy, the bench also keeps the valid input high with different field values, to show that those commands leave every pin unchanged.

// File: rtl/dac8_host_pkg.sv
package dac8_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLK_HI,
    ST_CLK_LO,
    ST_LEAD,
    ST_LATCH,
    ST_GAP,
    ST_REL_HI,
    ST_REL_LO
  } host_state_e;

  localparam logic [1:0] OP_WRITE_NOW  = 2'b00;
  localparam logic [1:0] OP_WRITE_HOLD = 2'b01;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac8_phase_timer.sv
module dac8_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/dac8_bit_shifter.sv
module dac8_bit_shifter #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_word,
  input  logic             shift,
  output logic             msb,
  output logic             last
);

  localparam int unsigned CW = $clog2(WIDTH);

  logic [WIDTH-1:0] sr;
  logic [CW-1:0]    left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      left <= '0;
    end else if (load) begin
      sr   <= load_word;
      left <= CW'(WIDTH - 1);
    end else if (shift) begin
      sr   <= {sr[WIDTH-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign msb  = sr[WIDTH-1];
  assign last = (left == '0);

endmodule

// File: rtl/dac8_serial_host.sv
module dac8_serial_host
  import dac8_host_pkg::*;
#(
  parameter int unsigned CHAN_W      = 3,
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned SYS_CLK_MHZ = 250,
  parameter int unsigned HALF_CYC    = 125,
  parameter int unsigned LEAD_CYC    = 13,
  parameter int unsigned LATCH_CYC   = 63,
  parameter int unsigned GAP_CYC     = 13,
  parameter int unsigned PULSE_CYC   = 63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CHAN_W-1:0] cmd_chan,
  input  logic              cmd_range,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [1:0]        cmd_op,
  output logic              dac_sclk,
  output logic              dac_sdi,
  output logic              dac_latch_n,
  output logic              dac_commit_n
);

  localparam int unsigned FRAME_W = CHAN_W + 1 + CODE_W;
  localparam int unsigned T_MAX   = max2(max2(HALF_CYC, LEAD_CYC),
                                         max2(max2(LATCH_CYC, GAP_CYC), PULSE_CYC));
  localparam int unsigned CNT_W   = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] HALF_M1  = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] LEAD_M1  = CNT_W'(LEAD_CYC - 1);
  localparam logic [CNT_W-1:0] LATCH_M1 = CNT_W'(LATCH_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_M1   = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_M1 = CNT_W'(PULSE_CYC - 1);

  // Elaboration-time checks of the pin timing limits at the given clock rate.
  initial begin
    assert (HALF_CYC >= 1 && LEAD_CYC >= 1 && LATCH_CYC >= 1 && GAP_CYC >= 1 && PULSE_CYC >= 1)
      else $error("every interval needs at least one cycle");
    assert (2 * HALF_CYC >= SYS_CLK_MHZ)
      else $error("serial clock above 1 MHz");
    assert (HALF_CYC * 1000 >= 50 * SYS_CLK_MHZ)
      else $error("data setup or valid window below 50 ns");
    assert ((HALF_CYC + LEAD_CYC) * 1000 >= 50 * SYS_CLK_MHZ)
      else $error("last clock edge to latch below 50 ns");
    assert ((GAP_CYC + HALF_CYC) * 1000 >= 50 * SYS_CLK_MHZ)
      else $error("latch recovery before next clock edge below 50 ns");
    assert (LATCH_CYC * 1000 >= 250 * SYS_CLK_MHZ)
      else $error("latch pulse below 250 ns");
    assert (PULSE_CYC * 1000 >= 250 * SYS_CLK_MHZ)
      else $error("update pulse below 250 ns");
  end

  host_state_e      state, nxt;
  logic             accept;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_msb, sh_last;

  assign accept = cmd_valid && cmd_ready;

  dac8_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  dac8_bit_shifter #(.WIDTH(FRAME_W)) u_shifter (
    .clk       (clk),
    .rst       (rst),
    .load      (sh_load),
    .load_word ({cmd_chan, cmd_range, cmd_code}),
    .shift     (sh_shift),
    .msb       (sh_msb),
    .last      (sh_last)
  );

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (cmd_op[1]) begin
          nxt     = ST_REL_HI;
          tmr_val = PULSE_M1;
        end else begin
          nxt     = ST_CLK_HI;
          tmr_val = HALF_M1;
          sh_load = 1'b1;
        end
      end
      ST_CLK_HI: if (tmr_expired) begin
        nxt      = ST_CLK_LO;
        tmr_load = 1'b1;
        tmr_val  = HALF_M1;
      end
      ST_CLK_LO: if (tmr_expired) begin
        tmr_load = 1'b1;
        if (sh_last) begin
          nxt     = ST_LEAD;
          tmr_val = LEAD_M1;
        end else begin
          nxt      = ST_CLK_HI;
          tmr_val  = HALF_M1;
          sh_shift = 1'b1;
        end
      end
      ST_LEAD: if (tmr_expired) begin
        nxt      = ST_LATCH;
        tmr_load = 1'b1;
        tmr_val  = LATCH_M1;
      end
      ST_LATCH: if (tmr_expired) begin
        nxt      = ST_GAP;
        tmr_load = 1'b1;
        tmr_val  = GAP_M1;
      end
      ST_GAP: if (tmr_expired) nxt = ST_IDLE;
      ST_REL_HI: if (tmr_expired) begin
        nxt      = ST_REL_LO;
        tmr_load = 1'b1;
        tmr_val  = PULSE_M1;
      end
      ST_REL_LO: if (tmr_expired) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cmd_ready    <= 1'b1;
      dac_sclk     <= 1'b1;
      dac_latch_n  <= 1'b1;
      dac_commit_n <= 1'b0;
    end else begin
      state       <= nxt;
      cmd_ready   <= (nxt == ST_IDLE);
      dac_sclk    <= (nxt != ST_CLK_LO);
      dac_latch_n <= (nxt != ST_LATCH);
      if (accept && (cmd_op[1] || cmd_op == OP_WRITE_HOLD)) begin
        dac_commit_n <= 1'b1;
      end else if (state == ST_REL_HI && tmr_expired) begin
        dac_commit_n <= 1'b0;
      end
    end
  end

  assign dac_sdi = sh_msb;

endmodule

// File: rtl/dac8_host_checker.sv
module dac8_host_checker #(
  parameter int unsigned HALF_CYC  = 125,
  parameter int unsigned LATCH_CYC = 63,
  parameter int unsigned PULSE_CYC = 63
) (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic dac_sclk,
  input logic dac_sdi,
  input logic dac_latch_n,
  input logic dac_commit_n
);

  logic [31:0] hi_run, latch_run, rel_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run    <= '0;
      latch_run <= '0;
      rel_run   <= '0;
    end else begin
      hi_run    <= dac_sclk      ? hi_run + 1'b1    : '0;
      latch_run <= !dac_latch_n  ? latch_run + 1'b1 : '0;
      rel_run   <= dac_commit_n  ? rel_run + 1'b1   : '0;
    end
  end

  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_idle_pins_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (dac_sclk && dac_latch_n));

  assert_data_moves_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_sdi) |-> ($rose(dac_sclk) || $past(cmd_valid && cmd_ready)));

  assert_high_phase_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_sclk) |-> (hi_run >= HALF_CYC));

  assert_fall_data_steady_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_sclk) |-> $stable(dac_sdi));

  assert_latch_clk_high_R4: assert property (@(posedge clk) disable iff (rst)
    !dac_latch_n |-> dac_sclk);

  assert_latch_width_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_latch_n) |-> (latch_run >= LATCH_CYC));

  assert_commit_not_in_latch_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_commit_n) |-> dac_latch_n);

  assert_commit_high_width_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_commit_n) |-> (rel_run >= PULSE_CYC));

endmodule

bind dac8_serial_host dac8_host_checker #(
  .HALF_CYC  (HALF_CYC),
  .LATCH_CYC (LATCH_CYC),
  .PULSE_CYC (PULSE_CYC)
) u_host_checker (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .dac_sclk     (dac_sclk),
  .dac_sdi      (dac_sdi),
  .dac_latch_n  (dac_latch_n),
  .dac_commit_n (dac_commit_n)
);

// File: tb/dac8_serial_host_bench.sv
`timescale 1ns/1ps
module dac8_serial_host_bench;

  localparam int H    = 125;
  localparam int LEAD = 13;
  localparam int LAT  = 63;
  localparam int GAP  = 13;
  localparam int P    = 63;
  localparam int WEND = 24*H + LEAD + LAT + GAP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_chan = '0;
  logic cmd_range = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [1:0] cmd_op = '0;
  logic cmd_ready, dac_sclk, dac_sdi, dac_latch_n, dac_commit_n;

  always #2 clk = ~clk;

  dac8_serial_host #(
    .SYS_CLK_MHZ(250), .HALF_CYC(H), .LEAD_CYC(LEAD),
    .LATCH_CYC(LAT), .GAP_CYC(GAP), .PULSE_CYC(P)
  ) u_dac8_serial_host (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_chan(cmd_chan), .cmd_range(cmd_range), .cmd_code(cmd_code), .cmd_op(cmd_op),
    .dac_sclk(dac_sclk), .dac_sdi(dac_sdi), .dac_latch_n(dac_latch_n),
    .dac_commit_n(dac_commit_n)
  );

  int checks = 0;
  int fails  = 0;
  bit started = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: elapsed cycles since acceptance decide every pin.
  bit        m_busy = 0;
  bit        m_commit_op = 0;
  int        m_k = 0;
  logic [11:0] m_frame = '0;
  logic      m_level = 0;
  logic      m_idle_sdi = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_busy <= 0; m_k <= 0; m_level <= 0; m_idle_sdi <= 0; m_commit_op <= 0;
    end else if (!m_busy) begin
      if (cmd_valid) begin
        m_busy <= 1; m_k <= 0; m_commit_op <= cmd_op[1];
        if (cmd_op[1]) m_level <= 1'b0;
        else begin
          if (cmd_op == 2'b01) m_level <= 1'b1;
          m_frame <= {cmd_chan, cmd_range, cmd_code};
          m_idle_sdi <= cmd_code[0];
        end
      end
    end else begin
      if (m_k + 1 == (m_commit_op ? 2*P : WEND)) m_busy <= 0;
      m_k <= m_k + 1;
    end
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      logic e_ready, e_sclk, e_sdi, e_latch, e_commit;
      e_ready = !m_busy; e_sclk = 1; e_sdi = m_idle_sdi; e_latch = 1; e_commit = m_level;
      if (m_busy && m_commit_op) e_commit = (m_k < P);
      if (m_busy && !m_commit_op) begin
        if (m_k < 24*H) begin
          e_sclk = (m_k % (2*H)) < H;
          e_sdi  = m_frame[11 - m_k/(2*H)];
        end else if (m_k >= 24*H + LEAD && m_k < 24*H + LEAD + LAT) begin
          e_latch = 0;
        end
      end
      checks++;
      if (cmd_ready !== e_ready || dac_sclk !== e_sclk || dac_sdi !== e_sdi ||
          dac_latch_n !== e_latch || dac_commit_n !== e_commit) begin
        fails++;
        if (cmd_ready !== e_ready)
          $display("FAIL R5 ready actual=%0b expected=%0b at %0t", cmd_ready, e_ready, $time);
        if (dac_sclk !== e_sclk)
          $display("FAIL R3 sclk actual=%0b expected=%0b at %0t", dac_sclk, e_sclk, $time);
        if (dac_sdi !== e_sdi)
          $display("FAIL R2 sdi actual=%0b expected=%0b at %0t", dac_sdi, e_sdi, $time);
        if (dac_latch_n !== e_latch)
          $display("FAIL R4 latch_n actual=%0b expected=%0b at %0t", dac_latch_n, e_latch, $time);
        if (dac_commit_n !== e_commit)
          $display("FAIL R6/R8 commit_n actual=%0b expected=%0b at %0t", dac_commit_n, e_commit, $time);
      end
    end
  end

  // Frame capture at the converter side (R2).
  logic [11:0] cap = '0;
  int nbits = 0;
  logic [11:0] exp_q[$];

  always @(negedge dac_sclk) if (!rst) begin
    cap = {cap[10:0], dac_sdi};
    nbits++;
  end

  always @(negedge dac_latch_n) if (!rst) begin
    logic [11:0] want;
    want = (exp_q.size() > 0) ? exp_q.pop_front() : 12'hxxx;
    check(nbits == 12, "R2", "bit count", nbits, 12);
    check(cap === want, "R2", "frame word", cap, want);
    nbits = 0;
  end

  task automatic send(input logic [1:0] op, input logic [2:0] ch,
                      input logic rg, input logic [7:0] cd);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_chan = ch; cmd_range = rg; cmd_code = cd;
    if (!op[1]) exp_q.push_back({ch, rg, cd});
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=busy expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset values
    check(cmd_ready === 1'b1, "R1", "ready", cmd_ready, 1);
    check(dac_sclk === 1'b1, "R1", "sclk", dac_sclk, 1);
    check(dac_sdi === 1'b0, "R1", "sdi", dac_sdi, 0);
    check(dac_latch_n === 1'b1, "R1", "latch_n", dac_latch_n, 1);
    check(dac_commit_n === 1'b0, "R1", "commit_n", dac_commit_n, 0);
    rst = 0;

    // R2, R3, R4: immediate write
    send(2'b00, 3'd0, 1'b0, 8'hA5);
    // R5: junk offered while busy must be ignored
    cmd_valid = 1; cmd_op = 2'b10; cmd_chan = 3'd6; cmd_range = 1; cmd_code = 8'h5A;
    repeat (40) @(negedge clk);
    cmd_valid = 0;
    wait_idle();
    check(dac_commit_n === 1'b0, "R6", "commit_n after immediate write", dac_commit_n, 0);

    send(2'b00, 3'd7, 1'b1, 8'h3C);
    wait_idle();

    // R6: deferred writes hold the update strobe high
    send(2'b01, 3'd2, 1'b0, 8'hFF);
    wait_idle();
    check(dac_commit_n === 1'b1, "R6", "commit_n after deferred write", dac_commit_n, 1);
    send(2'b01, 3'd5, 1'b1, 8'h00);
    wait_idle();

    // R7: immediate write with deferred data pending
    send(2'b00, 3'd4, 1'b0, 8'h81);
    wait_idle();
    check(dac_commit_n === 1'b1, "R7", "commit_n stays high", dac_commit_n, 1);

    // R8: commit from held level, then from low level, then the 11 code
    send(2'b10, 3'd0, 1'b0, 8'h00);
    wait_idle();
    check(dac_commit_n === 1'b0, "R8", "commit_n after commit", dac_commit_n, 0);
    send(2'b10, 3'd1, 1'b1, 8'h11);
    wait_idle();
    send(2'b11, 3'd3, 1'b0, 8'h22);
    wait_idle();
    check(dac_sclk === 1'b1 && nbits == 0, "R8", "no frame on commit", nbits, 0);

    send(2'b00, 3'd3, 1'b1, 8'h7E);
    wait_idle();
    check(exp_q.size() == 0, "R2", "all frames latched", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

endmodule